// File: doc/BRIEF.md
# Sparse ternary polynomial multiplier

This block multiplies a dense polynomial `a` of `N` coefficients by a sparse ternary polynomial `b` in the ring of polynomials modulo `X^N - 1`. Every coefficient is 11 bits wide and wraps modulo 2048. No multipliers are used. `b` is described by a list of `2D` index positions in an external synchronous memory. The first `D` entries mark coefficients equal to +1 and the last `D` mark coefficients equal to -1. For each listed position `p`, the block rotates `a` cyclically by `p` coefficient places. It then adds the rotated copy to every lane of an accumulator, or subtracts it.

Two position lists are available. One holds an ephemeral polynomial and the other a private polynomial. The mode sampled with `start` chooses the list and the operation:

- Mode 0 computes `a * b`.
- Mode 1 computes `a * (1 + 3b)`. It finishes with two extra steps: the accumulator tripled by a shift and an add, then `a` added once more.

The dense operand sits in a working register loaded in parallel. A backup copy can be taken from it and restored to it in one cycle. The control pins are plain levels and pulses.

Top module: `tern_polymul`

## Requirements
- R1: In mode 0, after `done` the result holds c_j = sum over positions p in entries 0..D-1 of a_((j-p) mod N), minus the same sum over entries D..2D-1, modulo 2048. Coefficient j sits at bits [11j+10 : 11j] of `a_in` and `result`. A position listed with both signs cancels, and a repeated position counts twice.
- R2: In mode 1, after `done` the result holds 3·(a*b) + a per coefficient, modulo 2048, where `b` is taken from the private list.
- R3: `done` is high for exactly one cycle. It rises after the (2D+2)-th rising edge following the edge that samples `start` in mode 0, and after the (2D+4)-th in mode 1. `busy` is high from the start edge until that same edge.
- R4: The list is read with a one-cycle read latency. `pos_addr` equals k after the k-th edge following the start edge, for k = 0..2D-1. Mode 0 reads `eph_pos` and mode 1 reads `prv_pos`.
- R5: The edge that samples `start` clears the accumulator, so `result` reads all zeros right after it, whatever an earlier run left.
- R6: While `busy` is high, `start`, `load_a`, `keep_a` and `restore_a` are ignored. The running result, its timing and the working operand used by later runs are unchanged.
- R7: When idle, `load_a` loads `a_in` into the working register, `keep_a` copies the working register into the backup, and `restore_a` copies the backup into the working register. If `load_a` and `restore_a` are both high, `load_a` wins.
- R8: While idle and without `start`, `result` does not change.
- R9: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | N*11 | Dense operand for parallel load |
| load_a | input | 1 | Load `a_in` into the working register |
| keep_a | input | 1 | Copy the working register to the backup |
| restore_a | input | 1 | Copy the backup to the working register |
| start | input | 1 | Begin a multiplication (sampled when idle) |
| mode | input | 1 | 0: a*b on ephemeral list; 1: a*(1+3b) on private list |
| pos_addr | output | AW | Read address into the position lists |
| eph_pos | input | PW | Read data of the ephemeral position list |
| prv_pos | input | PW | Read data of the private position list |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | N*11 | Accumulated product coefficients |

## Verification
The assertions rely on these conditions:

- Every position read from a list is below `N`.
- `2D` fits in the address space.
- The list memories answer one cycle after `pos_addr` is presented.

The bench keeps its memories synchronous and stores only in-range positions, including 0 and N-1. It writes the lists and the operand only between runs, except for one deliberate burst of `start` and loads in mid-run that checks R6.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int CW = 11;
  typedef logic [CW-1:0] coef_t;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_CLR,
    OP_ACC,
    OP_TRIPLE,
    OP_ADDA
  } acc_op_e;
endpackage

// File: rtl/tpm_rotator.sv
module tpm_rotator #(
  parameter int N  = 31,
  parameter int PW = 5,
  parameter int CW = 11
) (
  input  logic [N*CW-1:0] din,
  input  logic [PW-1:0]   amt,
  output logic [N*CW-1:0] dout
);
  localparam int W = N * CW;

  logic [W-1:0] stg [PW+1];
  assign stg[0] = din;

  // Stage s rotates left by 2^s mod N; rotations compose modulo N.
  for (genvar s = 0; s < PW; s++) begin : g_stage
    localparam int SH = (1 << s) % N;
    if (SH == 0) begin : g_pass
      assign stg[s+1] = stg[s];
    end else begin : g_rot
      logic [W-1:0] rot;
      assign rot = {stg[s][W-SH*CW-1:0], stg[s][W-1:W-SH*CW]};
      assign stg[s+1] = amt[s] ? rot : stg[s];
    end
  end

  assign dout = stg[PW];
endmodule

// File: rtl/tpm_lane.sv
module tpm_lane
  import tpm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  acc_op_e op,
  input  coef_t   rot,
  input  logic    neg,
  input  coef_t   a0,
  output coef_t   acc
);
  coef_t flip;
  assign flip = rot ^ {CW{neg}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else begin
      case (op)
        OP_CLR:    acc <= '0;
        OP_ACC:    acc <= acc + flip + coef_t'(neg);
        OP_TRIPLE: acc <= acc + (acc << 1);
        OP_ADDA:   acc <= acc + a0;
        default:   acc <= acc;
      endcase
    end
  end
endmodule

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
  import tpm_pkg::*;
#(
  parameter int D  = 4,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  output logic [AW-1:0] pos_addr,
  output logic          cap,
  output logic          neg,
  output acc_op_e       op,
  output logic          mode_q,
  output logic          busy,
  output logic          done
);
  localparam logic [AW:0] TOT_C = (AW+1)'(2 * D);
  localparam logic [AW:0] HALF_C = (AW+1)'(D);
  localparam logic [AW:0] LAST_C = (AW+1)'(2 * D - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX1, S_FIX2} st_e;
  st_e st;
  logic [AW:0] cnt;
  logic iss, m_v, m_neg, m_last, r_v, r_neg, r_last;

  assign iss      = (st == S_RUN) && (cnt < TOT_C);
  assign pos_addr = iss ? cnt[AW-1:0] : '0;
  assign cap      = m_v;
  assign neg      = r_neg;
  assign busy     = (st != S_IDLE);

  always_comb begin
    op = OP_HOLD;
    case (st)
      S_IDLE: if (start) op = OP_CLR;
      S_RUN:  if (r_v) op = OP_ACC;
      S_FIX1: op = OP_TRIPLE;
      S_FIX2: op = OP_ADDA;
      default: op = OP_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; mode_q <= 1'b0; done <= 1'b0;
      m_v <= 1'b0; m_neg <= 1'b0; m_last <= 1'b0;
      r_v <= 1'b0; r_neg <= 1'b0; r_last <= 1'b0;
    end else begin
      done   <= 1'b0;
      m_v    <= iss;
      m_neg  <= (cnt >= HALF_C);
      m_last <= (cnt == LAST_C);
      r_v    <= m_v;
      r_neg  <= m_neg;
      r_last <= m_v && m_last;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN; cnt <= '0; mode_q <= mode;
        end
        S_RUN: begin
          if (iss) cnt <= cnt + 1'b1;
          if (r_v && r_last) begin
            if (mode_q) st <= S_FIX1;
            else begin st <= S_IDLE; done <= 1'b1; end
          end
        end
        S_FIX1: st <= S_FIX2;
        default: begin st <= S_IDLE; done <= 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/tern_polymul.sv
module tern_polymul
  import tpm_pkg::*;
#(
  parameter int N  = 31,
  parameter int D  = 4,
  parameter int AW = 9,
  localparam int PW = $clog2(N),
  localparam int W  = N * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a_in,
  input  logic          load_a,
  input  logic          keep_a,
  input  logic          restore_a,
  input  logic          start,
  input  logic          mode,
  output logic [AW-1:0] pos_addr,
  input  logic [PW-1:0] eph_pos,
  input  logic [PW-1:0] prv_pos,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result
);
  logic [W-1:0] a_work, a_bak, rot_out, rot_q;
  logic [PW-1:0] pos_sel;
  logic cap, neg, mode_q;
  acc_op_e op;

  tpm_ctrl #(.D(D), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .pos_addr(pos_addr), .cap(cap), .neg(neg), .op(op),
    .mode_q(mode_q), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_work <= '0;
      a_bak  <= '0;
    end else if (!busy) begin
      if (load_a) a_work <= a_in;
      else if (restore_a) a_work <= a_bak;
      if (keep_a) a_bak <= a_work;
    end
  end

  assign pos_sel = mode_q ? prv_pos : eph_pos;

  tpm_rotator #(.N(N), .PW(PW), .CW(CW)) u_rot (
    .din(a_work), .amt(pos_sel), .dout(rot_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rot_q <= '0;
    else if (cap) rot_q <= rot_out;
  end

  for (genvar j = 0; j < N; j++) begin : g_lane
    coef_t acc_j;
    tpm_lane u_lane (
      .clk(clk), .rst_n(rst_n), .op(op),
      .rot(rot_q[j*CW +: CW]), .neg(neg),
      .a0(a_work[j*CW +: CW]), .acc(acc_j)
    );
    assign result[j*CW +: CW] = acc_j;
  end
endmodule

// File: rtl/tpm_chk.sv
module tpm_chk #(
  parameter int N  = 31,
  parameter int D  = 4,
  parameter int AW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [AW-1:0]   pos_addr,
  input logic [N*11-1:0] result
);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_addr) < 2 * D);

  assert_addr_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pos_addr == '0);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

bind tern_polymul tpm_chk #(.N(N), .D(D), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pos_addr(pos_addr), .result(result)
);

// File: tb/test_tern_polymul.sv
module test_tern_polymul;
  localparam int N = 17, D = 4, AW = 9, CW = 11;
  localparam int PW = $clog2(N), W = N * CW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0;
  logic load_a = 0, keep_a = 0, restore_a = 0, start = 0, mode = 0;
  logic [AW-1:0] pos_addr;
  logic [PW-1:0] eph_q, prv_q;
  logic busy, done;
  logic [W-1:0] result;

  logic [PW-1:0] eph_mem [512];
  logic [PW-1:0] prv_mem [512];
  always_ff @(posedge clk) begin
    eph_q <= eph_mem[pos_addr];
    prv_q <= prv_mem[pos_addr];
  end

  tern_polymul #(.N(N), .D(D), .AW(AW)) i_tern_polymul (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .load_a(load_a),
    .keep_a(keep_a), .restore_a(restore_a), .start(start), .mode(mode),
    .pos_addr(pos_addr), .eph_pos(eph_q), .prv_pos(prv_q),
    .busy(busy), .done(done), .result(result)
  );

  int n_chk = 0, n_fail = 0;
  int a_mdl [N];
  int bak_mdl [N];
  int exp_c [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic drive_a(input int seed);
    for (int j = 0; j < N; j++) begin
      a_mdl[j] = (seed * 37 + j * j * 13 + j * 101) % 2048;
      a_in[j*CW +: CW] = CW'(a_mdl[j]);
    end
    pulse(load_a);
  endtask

  task automatic set_pos(input bit prv, input int kind);
    for (int i = 0; i < 2 * D; i++) begin
      int p;
      case (kind)
        0: p = (i * 5 + 3) % N;
        1: p = (i < D) ? 0 : N - 1;
        2: p = 7;
        default: p = (i % 2) * (N - 1);
      endcase
      if (prv) prv_mem[i] = PW'(p);
      else eph_mem[i] = PW'(p);
    end
  endtask

  task automatic calc_exp(input bit fm);
    for (int j = 0; j < N; j++) begin
      int s = 0;
      for (int i = 0; i < 2 * D; i++) begin
        int p = fm ? int'(prv_mem[i]) : int'(eph_mem[i]);
        int v = a_mdl[((j - p) % N + N) % N];
        s = (i < D) ? s + v : s - v;
      end
      if (fm) s = 3 * s + a_mdl[j];
      exp_c[j] = ((s % 2048) + 2048) % 2048;
    end
  endtask

  task automatic check_result(input string req);
    int bad = -1;
    for (int j = 0; j < N; j++)
      if (bad < 0 && int'(result[j*CW +: CW]) != exp_c[j]) bad = j;
    if (bad < 0) chk(1'b1, req, "result", 0, 0);
    else chk(1'b0, req, $sformatf("coef %0d", bad),
             int'(result[bad*CW +: CW]), exp_c[bad]);
  endtask

  task automatic run(input bit fm, input bit inj, input string req);
    int lat = fm ? 2 * D + 4 : 2 * D + 2;
    logic [W-1:0] held;
    calc_exp(fm);
    @(negedge clk); start = 1'b1; mode = fm;
    @(negedge clk); start = 1'b0; mode = 1'b0;
    for (int k = 0; k <= lat; k++) begin
      if (k == 0) chk(result == '0, "R5", "cleared", 0, 0);
      chk(done == (k == lat), "R3", $sformatf("done k=%0d", k), done, k == lat);
      chk(busy == (k < lat), "R3", $sformatf("busy k=%0d", k), busy, k < lat);
      if (k < 2 * D)
        chk(int'(pos_addr) == k, "R4", "pos_addr", pos_addr, k);
      if (inj && k == 3) begin
        a_in = ~a_in; load_a = 1'b1; start = 1'b1; mode = ~fm;
        keep_a = 1'b1; restore_a = 1'b1;
      end else begin
        load_a = 1'b0; start = 1'b0; mode = 1'b0;
        keep_a = 1'b0; restore_a = 1'b0;
      end
      @(negedge clk);
    end
    chk(!done, "R3", "done single", done, 0);
    check_result(req);
    held = result;
    @(negedge clk);
    chk(result == held, "R8", "idle hold", 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin eph_mem[i] = '0; prv_mem[i] = '0; end
    for (int j = 0; j < N; j++) begin a_mdl[j] = 0; bak_mdl[j] = 0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R9", "reset flags", {busy, done}, 0);
    chk(result == '0, "R9", "reset result", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    set_pos(0, 0); set_pos(1, 1);
    drive_a(5);
    run(0, 0, "R1");
    run(1, 0, "R2");
    set_pos(0, 2);
    run(0, 0, "R1 cancel");
    set_pos(0, 3); set_pos(1, 0);
    drive_a(9);
    run(0, 0, "R1 repeat");
    run(1, 1, "R6");
    run(0, 0, "R6 operand kept");

    drive_a(1);
    pulse(keep_a);
    for (int j = 0; j < N; j++) bak_mdl[j] = a_mdl[j];
    drive_a(2);
    pulse(restore_a);
    for (int j = 0; j < N; j++) a_mdl[j] = bak_mdl[j];
    run(1, 0, "R7");

    summary();
  end
endmodule